// File: doc/BRIEF.md
# Special-Purpose Register Access Gate

This block sits beside a processor's execute stage and resolves every move-to and move-from special-purpose register (SPR) operation against a small local register set. For each access it looks at the 10-bit SPR number, the direction and the current privilege mode. In the same cycle it gives one of three outcomes: the access completes, it raises an illegal-instruction exception, or it raises a privilege exception. Completed reads return the register value. Completed writes update the register at the next clock edge.

The register set has a parameterised bank of user-visible scratch registers and a bank of supervisor-only scratch registers. It also has a context control register at SPR 560. The low byte of that register reports how many hardware register contexts exist, and this count is a build parameter. With a count of zero, the register reads as zero and drops every write. Privilege comes from the SPR address itself: bit 5 in big-endian numbering of the 10-bit number, which is bit index 4 counting from the least significant bit. When this bit is set, the register is supervisor-only. For a number that matches no register, this bit and the mode together select the exception type.

Top module: `spr_gate`

## Requirements
- R1: After reset every register holds zero. While `acc_valid` is low, all three response outputs and `rd_data` are zero.
- R2: An access to an implemented user-visible SPR completes (`resp_ok`) in either mode. Defaults: SPR 256 to 259. A write stores `wr_data`, and a later read returns it.
- R3: An access to an implemented supervisor-only SPR in supervisor mode (`user_mode` = 0) completes. Defaults: SPR 272 to 275 and 560.
- R4: An access to an implemented supervisor-only SPR in user mode (`user_mode` = 1) raises `resp_priv`. A write made this way leaves the register unchanged.
- R5: An access to an unimplemented SPR with bit index 4 of the number clear raises `resp_illegal` in either mode.
- R6: An access to an unimplemented SPR with bit index 4 set, made in supervisor mode, raises `resp_illegal`.
- R7: An access to an unimplemented SPR with bit index 4 set, made in user mode, raises `resp_priv`.
- R8: A valid access asserts exactly one of `resp_ok`, `resp_illegal` and `resp_priv`. An access that faults changes no register.
- R9: `rd_data` is zero unless the cycle carries a completed read.
- R10: With `NUM_CTX` = 0, the context control register (SPR 560) reads as zero. Writes to it complete but are discarded.
- R11: With `NUM_CTX` > 0, bits 7:0 of SPR 560 read as `NUM_CTX` and ignore writes. Bits 31:8 are stored by completed writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An SPR move is presented this cycle |
| acc_write | input | 1 | 1 = move to SPR (write), 0 = move from SPR (read) |
| acc_spr | input | 10 | SPR number |
| user_mode | input | 1 | Problem-state flag: 1 = user, 0 = supervisor |
| wr_data | input | 32 | Data for a write |
| resp_ok | output | 1 | Access completes |
| resp_illegal | output | 1 | Illegal-instruction exception |
| resp_priv | output | 1 | Privilege exception |
| rd_data | output | 32 | Read data for a completed read, otherwise zero |

## Verification
The bound checker watches the response outputs on every cycle. It confirms that they are one-hot for valid accesses and silent when idle. It also confirms that a supervisor-only number accessed from user mode always faults with a privilege exception, that neither a user-visible number nor supervisor mode ever yields a privilege exception, and that read data stays zero outside completed reads. Only the bench's sweeps can show that the implemented/unimplemented split is right and that written values come back on later reads. The same holds for the claims that faulting writes leave the register contents untouched and that the context register's count field and writable bits behave as the parameter dictates.

// File: rtl/spr_gate_pkg.sv
package spr_gate_pkg;

    localparam int SPR_W        = 10;
    localparam int DATA_W       = 32;
    // Big-endian bit 5 of a 10-bit number is bit index 4 from the LSB.
    localparam int PRIV_BIT_IDX = SPR_W - 1 - 5;
    localparam int CTX_FIELD_W  = 8;

    typedef enum logic [1:0] {
        RESP_NONE = 2'd0,
        RESP_OK   = 2'd1,
        RESP_ILL  = 2'd2,
        RESP_PRIV = 2'd3
    } resp_e;

endpackage

// File: rtl/spr_gate_decode.sv
module spr_gate_decode
    import spr_gate_pkg::*;
#(
    parameter int NUM_USR  = 4,
    parameter int NUM_SUP  = 4,
    parameter int USR_BASE = 256,
    parameter int SUP_BASE = 272,
    parameter int CTX_SPR  = 560
) (
    input  logic [SPR_W-1:0]   spr,
    output logic [NUM_USR-1:0] hit_usr,
    output logic [NUM_SUP-1:0] hit_sup,
    output logic               hit_ctx,
    output logic               implemented,
    output logic               priv_only
);

    for (genvar i = 0; i < NUM_USR; i++) begin : g_usr
        localparam logic [SPR_W-1:0] ADDR = SPR_W'(USR_BASE + i);
        assign hit_usr[i] = (spr == ADDR);
    end

    for (genvar j = 0; j < NUM_SUP; j++) begin : g_sup
        localparam logic [SPR_W-1:0] ADDR = SPR_W'(SUP_BASE + j);
        assign hit_sup[j] = (spr == ADDR);
    end

    assign hit_ctx     = (spr == SPR_W'(CTX_SPR));
    assign implemented = (|hit_usr) | (|hit_sup) | hit_ctx;
    assign priv_only   = spr[PRIV_BIT_IDX];

endmodule

// File: rtl/spr_gate_perm.sv
module spr_gate_perm
    import spr_gate_pkg::*;
(
    input  logic  valid,
    input  logic  implemented,
    input  logic  priv_only,
    input  logic  user_mode,
    output resp_e resp
);

    always_comb begin
        if (!valid) begin
            resp = RESP_NONE;
        end else if (priv_only && user_mode) begin
            resp = RESP_PRIV;
        end else if (implemented) begin
            resp = RESP_OK;
        end else begin
            resp = RESP_ILL;
        end
    end

endmodule

// File: rtl/spr_gate_regs.sv
module spr_gate_regs
    import spr_gate_pkg::*;
#(
    parameter int NUM_USR = 4,
    parameter int NUM_SUP = 4,
    parameter int NUM_CTX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_USR-1:0] hit_usr,
    input  logic [NUM_SUP-1:0] hit_sup,
    input  logic               hit_ctx,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_value
);

    localparam int  CTX_HI_W = DATA_W - CTX_FIELD_W;
    localparam bit  CTX_EN   = (NUM_CTX != 0);
    localparam logic [CTX_FIELD_W-1:0] CTX_COUNT = CTX_FIELD_W'(NUM_CTX);

    typedef struct packed {
        logic [NUM_USR-1:0][DATA_W-1:0] usr;
        logic [NUM_SUP-1:0][DATA_W-1:0] sup;
        logic [CTX_HI_W-1:0]            ctx_hi;
    } state_t;

    state_t st_d, st_q;
    logic [DATA_W-1:0] ctx_view;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_USR; i++) begin
                if (hit_usr[i]) st_d.usr[i] = wr_data;
            end
            for (int j = 0; j < NUM_SUP; j++) begin
                if (hit_sup[j]) st_d.sup[j] = wr_data;
            end
            if (hit_ctx && CTX_EN) begin
                st_d.ctx_hi = wr_data[DATA_W-1:CTX_FIELD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (CTX_EN) begin : g_ctx_on
            assign ctx_view = {st_q.ctx_hi, CTX_COUNT};
        end else begin : g_ctx_off
            assign ctx_view = '0;
        end
    endgenerate

    always_comb begin
        rd_value = '0;
        for (int i = 0; i < NUM_USR; i++) begin
            if (hit_usr[i]) rd_value = rd_value | st_q.usr[i];
        end
        for (int j = 0; j < NUM_SUP; j++) begin
            if (hit_sup[j]) rd_value = rd_value | st_q.sup[j];
        end
        if (hit_ctx) rd_value = rd_value | ctx_view;
    end

endmodule

// File: rtl/spr_gate.sv
module spr_gate
    import spr_gate_pkg::*;
#(
    parameter int NUM_USR  = 4,
    parameter int NUM_SUP  = 4,
    parameter int USR_BASE = 256,
    parameter int SUP_BASE = 272,
    parameter int CTX_SPR  = 560,
    parameter int NUM_CTX  = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [9:0]  acc_spr,
    input  logic        user_mode,
    input  logic [31:0] wr_data,
    output logic        resp_ok,
    output logic        resp_illegal,
    output logic        resp_priv,
    output logic [31:0] rd_data
);

    logic [NUM_USR-1:0] hit_usr;
    logic [NUM_SUP-1:0] hit_sup;
    logic               hit_ctx;
    logic               implemented;
    logic               priv_only;
    resp_e              resp;
    logic [DATA_W-1:0]  rd_value;

    spr_gate_decode #(
        .NUM_USR (NUM_USR),
        .NUM_SUP (NUM_SUP),
        .USR_BASE(USR_BASE),
        .SUP_BASE(SUP_BASE),
        .CTX_SPR (CTX_SPR)
    ) u_decode (
        .spr        (acc_spr),
        .hit_usr    (hit_usr),
        .hit_sup    (hit_sup),
        .hit_ctx    (hit_ctx),
        .implemented(implemented),
        .priv_only  (priv_only)
    );

    spr_gate_perm u_perm (
        .valid      (acc_valid),
        .implemented(implemented),
        .priv_only  (priv_only),
        .user_mode  (user_mode),
        .resp       (resp)
    );

    spr_gate_regs #(
        .NUM_USR(NUM_USR),
        .NUM_SUP(NUM_SUP),
        .NUM_CTX(NUM_CTX)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   ((resp == RESP_OK) && acc_write),
        .hit_usr (hit_usr),
        .hit_sup (hit_sup),
        .hit_ctx (hit_ctx),
        .wr_data (wr_data),
        .rd_value(rd_value)
    );

    assign resp_ok      = (resp == RESP_OK);
    assign resp_illegal = (resp == RESP_ILL);
    assign resp_priv    = (resp == RESP_PRIV);
    assign rd_data      = (resp_ok && !acc_write) ? rd_value : '0;

endmodule

// File: rtl/spr_gate_chk.sv
module spr_gate_chk #(
    parameter int CTX_SPR = 560,
    parameter int NUM_CTX = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [9:0]  acc_spr,
    input logic        user_mode,
    input logic        resp_ok,
    input logic        resp_illegal,
    input logic        resp_priv,
    input logic [31:0] rd_data
);

    // R8: one response per valid access, none when idle
    p_one_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({resp_ok, resp_illegal, resp_priv}) == (acc_valid ? 1 : 0));

    // R9: read data only on completed reads
    p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_ok && !acc_write) |-> (rd_data == 32'd0));

    // R7 (and R4): supervisor-only number from user mode always faults on privilege
    p_user_super_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && user_mode && acc_spr[4]) |-> resp_priv);

    // R5: user-visible numbers never give a privilege fault
    p_low_no_priv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_spr[4]) |-> !resp_priv);

    // R6: supervisor mode never gives a privilege fault
    p_sup_no_priv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !user_mode) |-> !resp_priv);

    generate
        if (NUM_CTX == 0) begin : g_blank
            // R10: context register reads as zero when no contexts exist
            p_ctx_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_valid && !acc_write && (acc_spr == 10'(CTX_SPR))) |-> (rd_data == 32'd0));
        end
    endgenerate

endmodule

bind spr_gate spr_gate_chk #(
    .CTX_SPR(CTX_SPR),
    .NUM_CTX(NUM_CTX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_spr     (acc_spr),
    .user_mode   (user_mode),
    .resp_ok     (resp_ok),
    .resp_illegal(resp_illegal),
    .resp_priv   (resp_priv),
    .rd_data     (rd_data)
);

// File: tb/spr_gate_bench.sv
module spr_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [9:0]  acc_spr = '0;
    logic        user_mode = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ok0, ill0, prv0, ok1, ill1, prv1;
    logic [31:0] rd0, rd1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] m_usr [4];
    logic [31:0] m_sup [4];
    logic [23:0] m_ctx_hi;

    always #4 clk = ~clk;

    spr_gate u_spr_gate (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_spr(acc_spr), .user_mode(user_mode), .wr_data(wr_data),
        .resp_ok(ok0), .resp_illegal(ill0), .resp_priv(prv0), .rd_data(rd0));

    spr_gate #(.NUM_CTX(3)) u_spr_gate_ctx (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_spr(acc_spr), .user_mode(user_mode), .wr_data(wr_data),
        .resp_ok(ok1), .resp_illegal(ill1), .resp_priv(prv1), .rd_data(rd1));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit is_impl(input int s);
        return (s >= 256 && s <= 259) || (s >= 272 && s <= 275) || s == 560;
    endfunction

    // {ok, illegal, priv}
    function automatic logic [2:0] exp_resp(input int s, input bit u);
        bit pb = s[4];
        if (u && pb)     return 3'b001;
        if (is_impl(s))  return 3'b100;
        return 3'b010;
    endfunction

    function automatic string tag_of(input int s, input bit u);
        bit pb = s[4];
        bit im = is_impl(s);
        if (im && !pb)       return "R2";
        if (im && pb && !u)  return "R3";
        if (im && pb && u)   return "R4";
        if (!pb)             return "R5";
        if (!u)              return "R6";
        return "R7";
    endfunction

    function automatic logic [31:0] pat(input int s, input bit u);
        return 32'hC3A5_0000 ^ (32'(s) << 4) ^ 32'(u);
    endfunction

    // Drive on falling edge, sample combinational outputs 1 ns later.
    task automatic access(input bit w, input int s, input bit u, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_spr = 10'(s); user_mode = u; wr_data = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_spr = '0; wr_data = '0;
        #1;
    endtask

    function automatic logic [31:0] model_rd(input int s);
        if (s >= 256 && s <= 259) return m_usr[s-256];
        if (s >= 272 && s <= 275) return m_sup[s-272];
        return 32'd0;
    endfunction

    task automatic readback_all(input string tag);
        for (int s = 256; s <= 259; s++) begin
            access(1'b0, s, 1'b0, 32'd0);
            check(tag, rd0, m_usr[s-256]);
        end
        for (int s = 272; s <= 275; s++) begin
            access(1'b0, s, 1'b0, 32'd0);
            check(tag, rd0, m_sup[s-272]);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_usr[i] = '0; m_sup[i] = '0; end
        m_ctx_hi = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: idle outputs
        idle();
        check("R1 idle resp", {29'd0, ok0, ill0, prv0}, 32'd0);
        check("R1 idle data", rd0, 32'd0);

        // Read sweep after reset: every number, both modes (R1..R7, R9)
        for (int u = 0; u < 2; u++) begin
            for (int s = 0; s < 1024; s++) begin
                access(1'b0, s, u[0], 32'd0);
                check(tag_of(s, u[0]), {29'd0, ok0, ill0, prv0}, {29'd0, exp_resp(s, u[0])});
                check("R1 R9 read after reset", rd0, 32'd0);
            end
        end

        // Write sweep: every number, both modes, model tracks completed writes (R2..R8)
        for (int u = 1; u >= 0; u--) begin
            for (int s = 0; s < 1024; s++) begin
                logic [2:0] e;
                e = exp_resp(s, u[0]);
                access(1'b1, s, u[0], pat(s, u[0]));
                check(tag_of(s, u[0]), {29'd0, ok0, ill0, prv0}, {29'd0, e});
                check("R9 write data", rd0, 32'd0);
                if (e == 3'b100) begin
                    if (s >= 256 && s <= 259) m_usr[s-256] = pat(s, u[0]);
                    if (s >= 272 && s <= 275) m_sup[s-272] = pat(s, u[0]);
                    if (s == 560) m_ctx_hi = pat(s, u[0])[31:8];
                end
            end
        end
        readback_all("R2 R3 R8 readback");
        access(1'b0, 560, 1'b0, 32'd0);
        check("R10 ctx after writes", rd0, 32'd0);
        check("R11 ctx count instance", rd1, {m_ctx_hi, 8'd3});

        // R4: user-mode write to supervisor register leaves it intact
        access(1'b1, 273, 1'b1, 32'hDEAD_BEEF);
        check("R4 priv fault", {29'd0, ok0, ill0, prv0}, 32'd1);
        access(1'b0, 273, 1'b0, 32'd0);
        check("R4 unchanged", rd0, m_sup[1]);

        // R8: faulting writes to unimplemented numbers change nothing
        access(1'b1, 15, 1'b1, 32'h1111_1111);
        access(1'b1, 1023, 1'b0, 32'h2222_2222);
        access(1'b1, 1023, 1'b1, 32'h3333_3333);
        readback_all("R8 fault no update");

        // R2: user mode write then read of user register
        access(1'b1, 258, 1'b1, 32'h0BAD_F00D); m_usr[2] = 32'h0BAD_F00D;
        access(1'b0, 258, 1'b1, 32'd0);
        check("R2 user rw", rd0, 32'h0BAD_F00D);

        // R10 / R11: context register with and without contexts
        access(1'b1, 560, 1'b0, 32'hABCD_EF55);
        check("R10 write ok", {29'd0, ok0, ill0, prv0}, 32'd4);
        access(1'b0, 560, 1'b0, 32'd0);
        check("R10 reads zero", rd0, 32'd0);
        check("R11 count ro, hi stored", rd1, 32'hABCD_EF03);

        // R1: back to idle
        idle();
        check("R1 idle again", {rd0[3:0] | rd1[3:0], ok0, ill0, prv0, ok1, ill1, prv1}, 10'd0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule